// File: doc/BRIEF.md
# Word Shift Unit with Carry

This unit shifts a 32-bit word and registers the result. It supports three kinds of shift: logical left, logical right and arithmetic right. A 2-bit operation select picks the kind of shift. It also picks where the amount comes from: a register value in a 6-bit field, or a 5-bit immediate carried in the low bits of that same field.

When the amount comes from a register, the top bit of the field is an out-of-range flag. When that flag is set, the shift is not performed. Instead the result is filled entirely with zeros, or with copies of the sign bit for the arithmetic shift.

Arithmetic shifts also produce a carry bit, with a matching write enable. Carry is set only when the source is negative and at least one 1 bit is shifted out. The register file, the stored carry and the instruction decode all sit outside this block. A valid pulse on the input comes back on the output one clock later, together with the result.

Top module: `word_shifter`

## Requirements
- R1: While reset is low, and in the first cycle after it, out_valid, result, carry_out and carry_we are all zero.
- R2: out_valid equals the previous cycle's in_valid. The result, carry_out and carry_we for a request are presented in the cycle after in_valid was high.
- R3: op_sel 2'b00 (logical left, register amount): the result is 0 if amt_field[5] is 1, and src_word shifted left by amt_field[4:0] otherwise.
- R4: op_sel 2'b01 (logical right, register amount): the result is 0 if amt_field[5] is 1, and src_word shifted right by amt_field[4:0] with zero fill otherwise.
- R5: op_sel 2'b10 (arithmetic right, register amount) with amt_field[5] = 1: the result is all ones for a negative source (bit 31 set) and zero otherwise.
- R6: For the R5 case, carry_out is 1 exactly when the source is negative and src_word[30:0] is nonzero.
- R7: For an arithmetic shift by n in 1..31, the result is the sign-filled right shift. carry_out is 1 exactly when the source is negative and its low n bits are not all zero.
- R8: op_sel 2'b11 (arithmetic right, immediate) uses only amt_field[4:0] and ignores amt_field[5]. An amount of 0 returns the source with carry_out 0.
- R9: op_sel 2'b10 with amt_field = 0 returns the source with carry_out 0.
- R10: carry_we is 1 only for the arithmetic selects (op_sel[1] = 1). For the logical selects both carry_we and carry_out are 0.
- R11: While in_valid is low, result, carry_out and carry_we keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| src_word | input | 32 | Word to shift |
| amt_field | input | 6 | Shift amount; bit 5 is the out-of-range flag for register selects |
| op_sel | input | 2 | 00 left, 01 right logical, 10 right arithmetic by register, 11 right arithmetic by immediate |
| out_valid | output | 1 | Registered result is new this cycle |
| result | output | 32 | Shifted word |
| carry_out | output | 1 | Carry for arithmetic shifts |
| carry_we | output | 1 | Carry should be written |

## Verification
An arithmetic shift by register with the out-of-range flag set does two things in the same cycle. It replaces the whole result with the sign fill, and it scans the low 31 source bits to decide the carry. The bench provokes this with negative sources that have zero and nonzero low bits, and with a positive source, all at amounts of 32 and above. Each case is judged on both the filled word and the carry against hand-derived values.

A second coincidence is tested as well: an immediate shift whose field also has bit 5 set. It must behave as an ordinary in-range shift, and the bench checks both the result and the carry for it.

// File: rtl/ws_pkg.sv
`timescale 1ns/1ps
package ws_pkg;
  localparam int WORD_W = 32;
  localparam int SH_W   = $clog2(WORD_W);
  localparam int AMT_W  = SH_W + 1;

  typedef enum logic [1:0] {
    OP_SHL_REG = 2'b00,
    OP_SHR_REG = 2'b01,
    OP_SAR_REG = 2'b10,
    OP_SAR_IMM = 2'b11
  } ws_op_e;

  // mask covering the low n positions, n < WORD_W
  function automatic logic [WORD_W-1:0] low_mask(input logic [SH_W-1:0] n);
    logic [WORD_W-1:0] one_vec;
    one_vec = {{(WORD_W-1){1'b0}}, 1'b1};
    return (one_vec << n) - one_vec;
  endfunction

  function automatic logic [WORD_W-1:0] sign_shift(input logic [WORD_W-1:0] v,
                                                   input logic [SH_W-1:0] n);
    return WORD_W'($signed(v) >>> n);
  endfunction
endpackage

// File: rtl/ws_shift_core.sv
`timescale 1ns/1ps
module ws_shift_core
  import ws_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int SW = SH_W
) (
  input  logic [W-1:0]  src,
  input  logic [SW:0]   amt,
  input  ws_op_e        op,
  output logic [W-1:0]  shifted,
  output logic          ovf_hit,
  output logic [SW-1:0] eff_amt
);
  logic          sign_bit;
  logic [W-1:0]  sign_fill;

  assign sign_bit  = src[W-1];
  assign sign_fill = {W{sign_bit}};
  assign eff_amt   = amt[SW-1:0];
  // the immediate form has no out-of-range flag
  assign ovf_hit   = amt[SW] && (op != OP_SAR_IMM);

  always_comb begin
    unique case (op)
      OP_SHL_REG: shifted = ovf_hit ? '0 : (src << eff_amt);
      OP_SHR_REG: shifted = ovf_hit ? '0 : (src >> eff_amt);
      default:    shifted = ovf_hit ? sign_fill : sign_shift(src, eff_amt);
    endcase
  end
endmodule

// File: rtl/ws_carry_calc.sv
`timescale 1ns/1ps
module ws_carry_calc
  import ws_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int SW = SH_W
) (
  input  logic [W-1:0]  src,
  input  logic [SW-1:0] eff_amt,
  input  logic          ovf_hit,
  input  ws_op_e        op,
  output logic          carry,
  output logic          carry_en
);
  logic         neg_src;
  logic [W-1:0] lost_bits;
  logic         any_lost;

  assign neg_src   = src[W-1];
  // out-of-range drops every bit below the sign
  assign lost_bits = ovf_hit ? {1'b0, src[W-2:0]} : (src & low_mask(eff_amt));
  assign any_lost  = |lost_bits;
  assign carry_en  = op[1];
  assign carry     = carry_en && neg_src && any_lost;
endmodule

// File: rtl/word_shifter.sv
`timescale 1ns/1ps
module word_shifter
  import ws_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int SW = SH_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] src_word,
  input  logic [SW:0]  amt_field,
  input  logic [1:0]   op_sel,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         carry_we
);
  ws_op_e        op;
  logic [W-1:0]  shifted;
  logic          ovf_hit;
  logic [SW-1:0] eff_amt;
  logic          carry_c;
  logic          carry_en_c;

  assign op = ws_op_e'(op_sel);

  ws_shift_core #(.W(W), .SW(SW)) u_core (
    .src(src_word), .amt(amt_field), .op(op),
    .shifted(shifted), .ovf_hit(ovf_hit), .eff_amt(eff_amt)
  );

  ws_carry_calc #(.W(W), .SW(SW)) u_carry (
    .src(src_word), .eff_amt(eff_amt), .ovf_hit(ovf_hit), .op(op),
    .carry(carry_c), .carry_en(carry_en_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      carry_out <= 1'b0;
      carry_we  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= shifted;
        carry_out <= carry_c;
        carry_we  <= carry_en_c;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);  // R2
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);  // R2
  AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_sel[1]) |=> (!carry_we && !carry_out));  // R10
  AST_ARITH_CARRY_WE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel[1]) |=> carry_we);  // R10
  AST_CARRY_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    carry_out |-> result[W-1]);  // R7
  AST_OVF_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_SAR_REG && amt_field[SW]) |=> (result == {W{$past(src_word[W-1])}}));  // R5
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(carry_out) && $stable(carry_we)));  // R11
endmodule

// File: tb/word_shifter_tb.sv
`timescale 1ns/1ps
module word_shifter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] src_word = '0;
  logic [5:0]  amt_field = '0;
  logic [1:0]  op_sel = '0;
  logic        out_valid;
  logic [31:0] result;
  logic        carry_out;
  logic        carry_we;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  word_shifter dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_word(src_word),
    .amt_field(amt_field), .op_sel(op_sel), .out_valid(out_valid),
    .result(result), .carry_out(carry_out), .carry_we(carry_we)
  );

  // {op, amt, src, expected result, expected carry, expected we, requirement}
  localparam int NV = 16;
  localparam logic [77:0] VEC [NV] = '{
    {2'b00, 6'd4,  32'h0000_00F1, 32'h0000_0F10, 1'b0, 1'b0, 4'd3},  // R3
    {2'b00, 6'h20, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 1'b0, 4'd3},  // R3 out of range
    {2'b00, 6'd31, 32'h0000_0003, 32'h8000_0000, 1'b0, 1'b0, 4'd3},  // R3
    {2'b01, 6'd8,  32'h8000_1200, 32'h0080_0012, 1'b0, 1'b0, 4'd4},  // R4
    {2'b01, 6'h3F, 32'h1234_5678, 32'h0000_0000, 1'b0, 1'b0, 4'd4},  // R4 out of range
    {2'b10, 6'd4,  32'hF000_0010, 32'hFF00_0001, 1'b0, 1'b1, 4'd7},  // R7 no ones lost
    {2'b10, 6'd4,  32'hF000_0018, 32'hFF00_0001, 1'b1, 1'b1, 4'd7},  // R7 one lost
    {2'b10, 6'd4,  32'h7000_0018, 32'h0700_0001, 1'b0, 1'b1, 4'd7},  // R7 positive
    {2'b10, 6'd31, 32'h8000_0002, 32'hFFFF_FFFF, 1'b1, 1'b1, 4'd7},  // R7
    {2'b10, 6'h20, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 1'b1, 4'd6},  // R5 R6
    {2'b10, 6'h25, 32'h8000_0001, 32'hFFFF_FFFF, 1'b1, 1'b1, 4'd6},  // R5 R6
    {2'b10, 6'h20, 32'h7FFF_FFFF, 32'h0000_0000, 1'b0, 1'b1, 4'd5},  // R5
    {2'b10, 6'd0,  32'h8000_0001, 32'h8000_0001, 1'b0, 1'b1, 4'd9},  // R9
    {2'b11, 6'd0,  32'hC000_0003, 32'hC000_0003, 1'b0, 1'b1, 4'd8},  // R8
    {2'b11, 6'h21, 32'h8000_0001, 32'hC000_0000, 1'b1, 1'b1, 4'd8},  // R8 flag ignored
    {2'b11, 6'd31, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 1'b1, 4'd8}   // R8
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", {out_valid, carry_out, carry_we}, 32'd0);
    check("R1", result, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {out_valid, carry_out, carry_we}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      op_sel    = VEC[i][77:76];
      amt_field = VEC[i][75:70];
      src_word  = VEC[i][69:38];
      in_valid  = 1'b1;
      @(negedge clk);
      check($sformatf("R%0d vec %0d result", VEC[i][3:0], i), result, VEC[i][37:6]);
      check($sformatf("R%0d vec %0d carry", VEC[i][3:0], i), {31'd0, carry_out}, {31'd0, VEC[i][5]});
      check($sformatf("R10 vec %0d carry_we", i), {31'd0, carry_we}, {31'd0, VEC[i][4]});
      check("R2 out_valid", {31'd0, out_valid}, 32'd1);
    end

    // R11: idle cycles hold outputs; R2 valid drops
    in_valid  = 1'b0;
    op_sel    = 2'b00;
    amt_field = 6'd1;
    src_word  = 32'h0000_0001;
    @(negedge clk);
    check("R2 idle out_valid", {31'd0, out_valid}, 32'd0);
    check("R11 hold result", result, 32'hFFFF_FFFF);
    check("R11 hold carry_we", {31'd0, carry_we}, 32'd1);
    @(negedge clk);
    check("R11 hold result 2", result, 32'hFFFF_FFFF);

    // R10: logical after arithmetic with carry set clears carry and we
    in_valid = 1'b1; op_sel = 2'b10; amt_field = 6'd1; src_word = 32'h8000_0001;
    @(negedge clk);
    check("R7 pre", {31'd0, carry_out}, 32'd1);
    op_sel = 2'b01; amt_field = 6'd1; src_word = 32'h8000_0001;
    @(negedge clk);
    check("R10 logical carry", {30'd0, carry_out, carry_we}, 32'd0);
    check("R4 result", result, 32'h4000_0000);

    // R1: reset mid-run clears everything
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid reset", result, 32'd0);
    check("R1 mid reset flags", {29'd0, out_valid, carry_out, carry_we}, 32'd0);
    finish_run();
  end
endmodule